// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block receives an asynchronous serial line and delivers bytes to a host. The line first passes through a two-flop synchronizer. The receiver then waits for a low level on the idle line. A baud tick at sixteen times the bit rate drives it. The start bit is checked again at its midpoint, and every later bit is sampled at its own midpoint. Data arrives least significant bit first, with a length of seven or eight bits. An optional even or odd parity bit and one or two stop bits follow the data.

When a frame completes, the receiver checks the parity and the first stop bit. It also checks whether the previous byte is still waiting. A clean frame goes into the data register and sets the data-full flag. A frame with a bad parity or stop bit is still written to the data register, but it raises the matching error flag instead of data-full. If the previous byte is still waiting, the new byte is dropped and the overrun flag is raised.

While any error flag is set, the receiver ignores the line until the host clears that flag with its own strobe. A single enable gates both interrupt requests: the data-full request and the receive-error request.

Top module: `uart_rx_lockout`

## Requirements
- R1: After reset, rx_data is 0. full_flag, ovr_flag, frm_flag, par_flag, irq_full and irq_err are all 0.
- R2: A frame starts when the synchronized line is low on a baud tick while the receiver is idle. The line must still be low 8 ticks later, at mid start bit. A low pulse shorter than half a bit returns the receiver to idle, and no byte is received.
- R3: Each bit lasts 16 ticks. Data bits are taken least significant bit first. With len_short=0 there are 8 data bits. With len_short=1 there are 7 data bits, and rx_data[7] reads 0.
- R4: When par_en=1, one parity bit follows the data. The count of ones across the data bits and the parity bit must be even when par_odd=0 and odd when par_odd=1. On a mismatch, par_flag is set, rx_data takes the byte and full_flag stays 0.
- R5: The first stop bit must be 1. If it is 0, frm_flag is set, rx_data takes the byte and full_flag stays 0. With stop_two=1 the second stop bit is not checked.
- R6: A frame that passes every check loads rx_data and sets full_flag to 1.
- R7: If full_flag is still 1 when a frame completes, ovr_flag is set and rx_data keeps its old value.
- R8: While ovr_flag, frm_flag or par_flag is 1, the receiver starts no new frame, and rx_data and full_flag do not change because of the line.
- R9: A pulse on rd_strobe or clr_full clears full_flag. Each error flag is cleared only by its own strobe: clr_ovr, clr_frm or clr_par.
- R10: irq_full is full_flag AND irq_en. irq_err is (ovr_flag OR frm_flag OR par_flag) AND irq_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| len_short | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| stop_two | input | 1 | 1 = two stop bits |
| irq_en | input | 1 | Enable for both interrupt requests |
| rd_strobe | input | 1 | Host read of the data register; clears full_flag |
| clr_full | input | 1 | Clears full_flag |
| clr_ovr | input | 1 | Clears ovr_flag |
| clr_frm | input | 1 | Clears frm_flag |
| clr_par | input | 1 | Clears par_flag |
| rx_data | output | 8 | Receive data register |
| full_flag | output | 1 | Data register holds an unread byte |
| ovr_flag | output | 1 | Overrun error |
| frm_flag | output | 1 | Framing error |
| par_flag | output | 1 | Parity error |
| irq_full | output | 1 | Data-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
Some properties are checked on every cycle:
- rx_data does not change when an overrun occurs.
- A framing or parity error never appears together with a new data-full flag.
- An error flag stays set until its own strobe clears it.
- full_flag falls only after a read or clear strobe.
- rx_data stays frozen while the receiver is locked out.
- Both interrupts stay silent while the enable is low.

Only the bench scenarios can show the following:
- Bit order and the seven-bit length.
- The parity arithmetic for both senses.
- That the second stop bit is ignored.
- That a short glitch is rejected.
- That a locked-out receiver drops a whole frame on the line.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int URX_DW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [URX_DW-1:0] data;
        logic              frm_bad;
        logic              par_bad;
    } rx_frame_t;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_s;

    sync_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (STAGES > 1) begin
            s_d.pipe = {s_q.pipe[STAGES-2:0], din};
        end else begin
            s_d.pipe[0] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pipe: '1};
        else        s_q <= s_d;
    end

    assign dout = s_q.pipe[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = URX_DW
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line,
    input  logic      locked,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      len_short,
    input  logic      stop_two,
    output rx_frame_t frame
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_L  = BIT_W'(DW - 1);
    localparam logic [BIT_W-1:0] LAST_S  = BIT_W'(DW - 2);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [DW-1:0]     sr;
        logic              ones;
        logic              par_bad;
        logic              frm_bad;
        logic              done;
    } fr_s;

    fr_s f_d, f_q;
    logic [BIT_W-1:0] last_bit;
    logic             ones_all;

    assign last_bit = len_short ? LAST_S : LAST_L;
    assign ones_all = f_q.ones ^ line;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        if (tick) begin
            unique case (f_q.st)
                ST_IDLE: begin
                    if (!locked && !line) begin
                        f_d.st  = ST_START;
                        f_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (f_q.cnt == HALF_M1) begin
                        f_d.cnt = '0;
                        if (!line) begin
                            f_d.st      = ST_DATA;
                            f_d.bitn    = '0;
                            f_d.sr      = '0;
                            f_d.ones    = 1'b0;
                            f_d.par_bad = 1'b0;
                            f_d.frm_bad = 1'b0;
                        end else begin
                            f_d.st = ST_IDLE;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (f_q.cnt == FULL_M1) begin
                        f_d.cnt  = '0;
                        f_d.sr   = {line, f_q.sr[DW-1:1]};
                        f_d.ones = ones_all;
                        if (f_q.bitn == last_bit) begin
                            f_d.st = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            f_d.bitn = f_q.bitn + 1'b1;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (f_q.cnt == FULL_M1) begin
                        f_d.cnt     = '0;
                        f_d.par_bad = par_odd ? !ones_all : ones_all;
                        f_d.st      = ST_STOP;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (f_q.cnt == FULL_M1) begin
                        f_d.cnt     = '0;
                        f_d.frm_bad = !line;
                        f_d.done    = 1'b1;
                        f_d.st      = stop_two ? ST_STOP2 : ST_IDLE;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_STOP2: begin
                    if (f_q.cnt == FULL_M1) begin
                        f_d.cnt = '0;
                        f_d.st  = ST_IDLE;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{st: ST_IDLE, default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    always_comb begin
        frame.valid   = f_q.done;
        frame.data    = len_short ? {1'b0, f_q.sr[DW-1:1]} : f_q.sr;
        frame.frm_bad = f_q.frm_bad;
        frame.par_bad = f_q.par_bad;
    end
endmodule

// File: rtl/urx_status.sv
module urx_status
    import urx_pkg::*;
#(
    parameter int DW = URX_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rx_frame_t     frame,
    input  logic          rd_strobe,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    input  logic          irq_en,
    output logic [DW-1:0] data,
    output logic          full,
    output logic          ovr,
    output logic          frm,
    output logic          par,
    output logic          irq_full,
    output logic          irq_err,
    output logic          locked
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          ovr;
        logic          frm;
        logic          par;
    } stat_s;

    stat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rd_strobe || clr_full) s_d.full = 1'b0;
        if (clr_ovr)               s_d.ovr  = 1'b0;
        if (clr_frm)               s_d.frm  = 1'b0;
        if (clr_par)               s_d.par  = 1'b0;
        if (frame.valid) begin
            if (s_q.full) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.data = frame.data;
                if (frame.frm_bad || frame.par_bad) begin
                    if (frame.frm_bad) s_d.frm = 1'b1;
                    if (frame.par_bad) s_d.par = 1'b1;
                end else begin
                    s_d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign data     = s_q.data;
    assign full     = s_q.full;
    assign ovr      = s_q.ovr;
    assign frm      = s_q.frm;
    assign par      = s_q.par;
    assign locked   = s_q.ovr | s_q.frm | s_q.par;
    assign irq_full = s_q.full & irq_en;
    assign irq_err  = locked & irq_en;
endmodule

// File: rtl/uart_rx_lockout.sv
module uart_rx_lockout
    import urx_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int DW        = URX_DW,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rx_in,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          len_short,
    input  logic          stop_two,
    input  logic          irq_en,
    input  logic          rd_strobe,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] rx_data,
    output logic          full_flag,
    output logic          ovr_flag,
    output logic          frm_flag,
    output logic          par_flag,
    output logic          irq_full,
    output logic          irq_err
);
    logic      line_s;
    logic      locked;
    rx_frame_t frame;

    urx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (line_s)
    );

    urx_frame #(.OSR(OSR), .DW(DW)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .line     (line_s),
        .locked   (locked),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .len_short(len_short),
        .stop_two (stop_two),
        .frame    (frame)
    );

    urx_status #(.DW(DW)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame    (frame),
        .rd_strobe(rd_strobe),
        .clr_full (clr_full),
        .clr_ovr  (clr_ovr),
        .clr_frm  (clr_frm),
        .clr_par  (clr_par),
        .irq_en   (irq_en),
        .data     (rx_data),
        .full     (full_flag),
        .ovr      (ovr_flag),
        .frm      (frm_flag),
        .par      (par_flag),
        .irq_full (irq_full),
        .irq_err  (irq_err),
        .locked   (locked)
    );
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_en,
    input logic          rd_strobe,
    input logic          clr_full,
    input logic          clr_ovr,
    input logic          clr_frm,
    input logic          clr_par,
    input logic [DW-1:0] rx_data,
    input logic          full_flag,
    input logic          ovr_flag,
    input logic          frm_flag,
    input logic          par_flag,
    input logic          irq_full,
    input logic          irq_err
);
    // R7
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> rx_data == $past(rx_data));

    // R5
    frm_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_flag) |-> !full_flag);

    // R4
    par_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_flag) |-> !full_flag);

    // R6
    full_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flag) |-> !(ovr_flag || frm_flag || par_flag));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag && !clr_ovr |=> ovr_flag);

    // R9
    frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_flag && !clr_frm |=> frm_flag);

    // R9
    full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_flag) |-> $past(rd_strobe || clr_full));

    // R8
    locked_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag || frm_flag || par_flag) && !(clr_ovr || clr_frm || clr_par)
        |=> $stable(rx_data));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_full && !irq_err);
endmodule

bind uart_rx_lockout urx_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_en   (irq_en),
    .rd_strobe(rd_strobe),
    .clr_full (clr_full),
    .clr_ovr  (clr_ovr),
    .clr_frm  (clr_frm),
    .clr_par  (clr_par),
    .rx_data  (rx_data),
    .full_flag(full_flag),
    .ovr_flag (ovr_flag),
    .frm_flag (frm_flag),
    .par_flag (par_flag),
    .irq_full (irq_full),
    .irq_err  (irq_err)
);

// File: tb/tb_uart_rx_lockout.sv
`timescale 1ns/1ps
module tb_uart_rx_lockout;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;
    localparam int NVEC     = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       rx_in = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0, len_short = 1'b0, stop_two = 1'b0;
    logic       irq_en = 1'b0;
    logic       rd_strobe = 1'b0, clr_full = 1'b0;
    logic       clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       full_flag, ovr_flag, frm_flag, par_flag, irq_full, irq_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] tdiv = '0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
    assign baud_tick = (tdiv == 2'd3);

    uart_rx_lockout dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_in(rx_in),
        .par_en(par_en), .par_odd(par_odd), .len_short(len_short),
        .stop_two(stop_two), .irq_en(irq_en), .rd_strobe(rd_strobe),
        .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm),
        .clr_par(clr_par), .rx_data(rx_data), .full_flag(full_flag),
        .ovr_flag(ovr_flag), .frm_flag(frm_flag), .par_flag(par_flag),
        .irq_full(irq_full), .irq_err(irq_err)
    );

    // fields: par_en odd len7 stop2 flip stop1 | data | exp_full exp_par exp_frm | exp_data
    localparam logic [24:0] VEC [0:NVEC-1] = '{
        {6'b000001, 8'hA5, 3'b100, 8'hA5},  // R3 R6 8 bits
        {6'b000001, 8'h3C, 3'b100, 8'h3C},  // R3 R6
        {6'b100001, 8'h96, 3'b100, 8'h96},  // R4 even good
        {6'b110001, 8'h01, 3'b100, 8'h01},  // R4 odd good
        {6'b100011, 8'h5A, 3'b010, 8'h5A},  // R4 even bad
        {6'b110011, 8'hFF, 3'b010, 8'hFF},  // R4 odd bad
        {6'b000000, 8'h81, 3'b001, 8'h81},  // R5 stop low
        {6'b001001, 8'hFF, 3'b100, 8'h7F},  // R3 seven bits
        {6'b101001, 8'h2B, 3'b100, 8'h2B},  // R3 R4 seven bits even
        {6'b000101, 8'h6E, 3'b100, 8'h6E},  // R5 second stop ignored
        {6'b000100, 8'h19, 3'b001, 8'h19},  // R5 two stops, first low
        {6'b111011, 8'h40, 3'b010, 8'h40}   // R4 seven bits odd bad
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rx_in = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic pe, input logic od, input logic l7,
                              input logic s2, input logic flip, input logic st1,
                              input logic [7:0] d);
        int   nb;
        logic pb;
        par_en = pe; par_odd = od; len_short = l7; stop_two = s2;
        nb = l7 ? 7 : 8;
        pb = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            pb = pb ^ d[i];
            send_bit(d[i]);
        end
        if (pe) send_bit(pb ^ od ^ flip);
        send_bit(st1);
        if (s2) send_bit(1'b0);
        rx_in = 1'b1;
        repeat (2 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        case (which)
            0: rd_strobe = 1'b1;
            1: clr_full  = 1'b1;
            2: clr_ovr   = 1'b1;
            3: clr_frm   = 1'b1;
            default: clr_par = 1'b1;
        endcase
        @(negedge clk);
        rd_strobe = 1'b0; clr_full = 1'b0;
        clr_ovr = 1'b0; clr_frm = 1'b0; clr_par = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int k = 0; k < 5; k++) pulse(k);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data", rx_data, 0);
        check("R1 flags", {full_flag, ovr_flag, frm_flag, par_flag}, 0);
        check("R1 irqs", {irq_full, irq_err}, 0);
        repeat (BIT_CLKS) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            send_frame(VEC[v][24], VEC[v][23], VEC[v][22], VEC[v][21],
                       VEC[v][20], VEC[v][19], VEC[v][18:11]);
            check($sformatf("R3/R4/R5/R6 vec%0d data", v), rx_data, VEC[v][7:0]);
            check($sformatf("R4/R5/R6 vec%0d flags", v),
                  {full_flag, par_flag, frm_flag}, VEC[v][10:8]);
            check($sformatf("R7 vec%0d no overrun", v), ovr_flag, 0);
            clear_all();
        end

        // R2 glitch shorter than half a bit
        rx_in = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_in = 1'b1;
        repeat (12 * BIT_CLKS) @(negedge clk);
        check("R2 glitch rejected", {full_flag, frm_flag, par_flag}, 0);
        send_frame(0, 0, 0, 0, 0, 1, 8'hC3);
        check("R2 frame after glitch", rx_data, 8'hC3);

        // R10 interrupts
        irq_en = 1'b1;
        @(negedge clk);
        check("R10 irq_full", {irq_full, irq_err}, 2'b10);
        irq_en = 1'b0;
        @(negedge clk);
        check("R10 irq gated", {irq_full, irq_err}, 2'b00);

        // R7 overrun: C3 still unread
        send_frame(0, 0, 0, 0, 0, 1, 8'h77);
        check("R7 ovr set", {full_flag, ovr_flag}, 2'b11);
        check("R7 data kept", rx_data, 8'hC3);
        irq_en = 1'b1;
        @(negedge clk);
        check("R10 irq_err", irq_err, 1);
        irq_en = 1'b0;

        // R8 lockout: clear full, keep overrun, send frame
        pulse(0);
        send_frame(0, 0, 0, 0, 0, 1, 8'h12);
        check("R8 locked data", rx_data, 8'hC3);
        check("R8 locked full", full_flag, 0);

        // R9 error flags cleared only by own strobe
        pulse(0); pulse(1); pulse(3); pulse(4);
        check("R9 ovr survives others", ovr_flag, 1);
        pulse(2);
        check("R9 ovr cleared", ovr_flag, 0);
        send_frame(0, 0, 0, 0, 0, 0, 8'h55);
        check("R9 frm set", frm_flag, 1);
        pulse(0); pulse(2); pulse(4);
        check("R9 frm survives others", frm_flag, 1);
        pulse(3);
        check("R9 frm cleared", frm_flag, 0);
        send_frame(0, 0, 0, 0, 0, 1, 8'hE4);
        check("R8 receive after unlock", rx_data, 8'hE4);
        check("R9 full set", full_flag, 1);
        pulse(1);
        check("R9 clr_full", full_flag, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule